// File: doc/BRIEF.md
# Branch Decision and Next-Address Unit

This block takes one decoded control-transfer candidate per transfer: an 8-bit opcode, the flag byte, the address of the opcode, the operand bytes that follow it, the 16-bit HL pair and the 8-bit B register. It decides whether the instruction transfers control and computes the next program counter. It also computes the return address and raises a push request for calls and restarts, or a pop request for returns. The stack access itself belongs to the surrounding core. For the loop instruction, the block also returns the decremented B value with a write enable.

Operands stream in on a valid/ready port and results leave on a valid/ready port, one register stage apart. A candidate is accepted in any cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the result register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result register is frozen and `in_ready` is low, so back-pressure reaches the producer combinationally and no result is ever dropped.

Top module: `bru_unit`

## Requirements
- R1: A candidate accepted on an edge appears on the result port in the next cycle. While `out_valid` is high and `out_ready` is low, every result field holds its value and `in_ready` is low. Otherwise `in_ready` is high.
- R2: The 3-bit condition field `cc` = opcode[5:3] selects a flag from the flag byte: 0/1 select Z (bit 6), 2/3 select C (bit 0), 4/5 select parity/overflow (bit 2), 6/7 select S (bit 7). An even code holds when the flag is 0 and an odd code holds when the flag is 1.
- R3: Opcode 0xC3 always jumps, and opcodes 11ccc010 jump only when the condition holds. The target is `in_imm`, where operand byte 1 (low) is `in_imm[7:0]` and operand byte 2 (high) is `in_imm[15:8]`. The length is 3 bytes.
- R4: Opcode 0x18 always branches, and 0x20/0x28/0x30/0x38 branch only when the condition holds, using cc = {0, opcode[4:3]}. The target is opcode address + 2 + the sign-extended `in_imm[7:0]`, modulo 2^16. The length is 2 bytes.
- R5: Opcode 0x10 returns `out_b` = B − 1 (0x00 wraps to 0xFF) with `out_b_we` = 1. It branches to the relative target (as in R4) only when the new B is nonzero.
- R6: Opcode 0xE9 always transfers to `in_hl`. The length is 1 byte.
- R7: Opcode 0xCD always calls, and 11ccc100 calls only when the condition holds. The target is `in_imm`. When the call is taken, `out_push` = 1 and the pushed return address is opcode address + 3.
- R8: Opcode 11ttt111 is a restart. It always transfers to opcode AND 0x38 and pushes opcode address + 1.
- R9: Opcode 0xC9 always returns, and 11ccc000 returns only when the condition holds. A taken return sets `out_pop` = 1 and `out_taken` = 1. The stack supplies the new PC, and `out_next_pc` carries opcode address + 1.
- R10: `out_ret_addr` always equals opcode address + instruction length. A transfer that is not taken gives `out_next_pc` = `out_ret_addr`, with no push and no pop.
- R11: Any other opcode gives `out_taken` = 0, `out_next_pc` = opcode address + 1, and no push, no pop and no B write.
- R12: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Candidate present |
| in_ready | output | 1 | Candidate can be accepted |
| in_opcode | input | 8 | Opcode byte |
| in_flags | input | 8 | Flag byte (C bit 0, P/V bit 2, Z bit 6, S bit 7) |
| in_pc | input | 16 | Address of the opcode |
| in_imm | input | 16 | Operand bytes {second, first} |
| in_hl | input | 16 | HL pair |
| in_b | input | 8 | B register |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_taken | output | 1 | Control transfer taken |
| out_next_pc | output | 16 | Next program counter |
| out_push | output | 1 | Push return address |
| out_pop | output | 1 | Pop new PC from stack |
| out_ret_addr | output | 16 | Address of the following instruction |
| out_b_we | output | 1 | Write back B |
| out_b | output | 8 | Decremented B |

## Verification
The hardest cases to reach are the arithmetic corners of the loop and relative forms. One is a loop instruction whose B is 1, so the new B is zero and the branch is not taken. Another is a B of 0 that wraps to 0xFF and branches. A third is a negative displacement that carries the target below address zero. Directed candidates place these values deliberately, alongside a sweep of all 256 opcodes under both all-clear and all-set flag bytes. A random `out_ready` pattern holds results in place across many cycles, which exercises the frozen-output and back-pressure path while new candidates wait.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [3:0] {
    K_NONE, K_JP, K_JPCC, K_JR, K_JRCC, K_LOOP,
    K_JPHL, K_CALL, K_CALLCC, K_RET, K_RETCC, K_RST
  } kind_t;

  localparam int FLAG_C  = 0;
  localparam int FLAG_PV = 2;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_S  = 7;
  localparam int BYTE_W  = 8;
endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  output kind_t             kind,
  output logic [1:0]        len,
  output logic [2:0]        cc
);
  always_comb begin
    kind = K_NONE;
    len  = 2'd1;
    cc   = op[5:3];
    if (op[7:6] == 2'b11) begin
      unique case (op[2:0])
        3'b000:  kind = K_RETCC;
        3'b010:  begin kind = K_JPCC;   len = 2'd3; end
        3'b100:  begin kind = K_CALLCC; len = 2'd3; end
        3'b111:  kind = K_RST;
        default: ;
      endcase
    end
    unique case (op)
      8'hC3: begin kind = K_JP;   len = 2'd3; end
      8'hCD: begin kind = K_CALL; len = 2'd3; end
      8'hC9: kind = K_RET;
      8'hE9: kind = K_JPHL;
      8'h18: begin kind = K_JR;   len = 2'd2; end
      8'h10: begin kind = K_LOOP; len = 2'd2; end
      8'h20, 8'h28, 8'h30, 8'h38: begin
        kind = K_JRCC;
        len  = 2'd2;
        cc   = {1'b0, op[4:3]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
(
  input  logic [2:0]        cc,
  input  logic [BYTE_W-1:0] flags,
  output logic              holds
);
  logic picked;
  always_comb begin
    unique case (cc[2:1])
      2'd0: picked = flags[FLAG_Z];
      2'd1: picked = flags[FLAG_C];
      2'd2: picked = flags[FLAG_PV];
      default: picked = flags[FLAG_S];
    endcase
    holds = cc[0] ? picked : ~picked;
  end
endmodule

// File: rtl/bru_target.sv
module bru_target
  import bru_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  kind_t             kind,
  input  logic [1:0]        len,
  input  logic [BYTE_W-1:0] op,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] imm,
  input  logic [ADDR_W-1:0] hl,
  output logic [ADDR_W-1:0] fall,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - BYTE_W;
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] rst_vec;

  assign fall     = pc + ADDR_W'(len);
  assign disp_ext = {{EXT_W{imm[BYTE_W-1]}}, imm[BYTE_W-1:0]};
  assign rst_vec  = {{EXT_W{1'b0}}, op & 8'h38};

  always_comb begin
    unique case (kind)
      K_JP, K_JPCC, K_CALL, K_CALLCC: target = imm;
      K_JR, K_JRCC, K_LOOP:           target = fall + disp_ext;
      K_JPHL:                         target = hl;
      K_RST:                          target = rst_vec;
      default:                        target = fall;
    endcase
  end
endmodule

// File: rtl/bru_unit.sv
module bru_unit
  import bru_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_opcode,
  input  logic [7:0]        in_flags,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [ADDR_W-1:0] in_imm,
  input  logic [ADDR_W-1:0] in_hl,
  input  logic [7:0]        in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_taken,
  output logic [ADDR_W-1:0] out_next_pc,
  output logic              out_push,
  output logic              out_pop,
  output logic [ADDR_W-1:0] out_ret_addr,
  output logic              out_b_we,
  output logic [7:0]        out_b
);
  typedef struct packed {
    logic              taken;
    logic [ADDR_W-1:0] next_pc;
    logic              push;
    logic              pop;
    logic [ADDR_W-1:0] ret_addr;
    logic              b_we;
    logic [7:0]        b;
  } res_t;

  kind_t             kind;
  logic [1:0]        len;
  logic [2:0]        cc;
  logic              cond_ok;
  logic [ADDR_W-1:0] fall, target;
  logic [7:0]        b_dec;
  logic              taken, is_ret, is_push;
  res_t              res_d, res_q;
  logic              load;

  bru_decode u_dec (.op(in_opcode), .kind(kind), .len(len), .cc(cc));
  bru_cond   u_cond (.cc(cc), .flags(in_flags), .holds(cond_ok));
  bru_target #(.ADDR_W(ADDR_W)) u_tgt (
    .kind(kind), .len(len), .op(in_opcode), .pc(in_pc), .imm(in_imm),
    .hl(in_hl), .fall(fall), .target(target)
  );

  assign b_dec = in_b - 8'd1;

  always_comb begin
    unique case (kind)
      K_JP, K_JR, K_JPHL, K_CALL, K_RET, K_RST: taken = 1'b1;
      K_JPCC, K_JRCC, K_CALLCC, K_RETCC:        taken = cond_ok;
      K_LOOP:                                   taken = (b_dec != 8'd0);
      default:                                  taken = 1'b0;
    endcase
    is_ret  = (kind == K_RET) || (kind == K_RETCC);
    is_push = (kind == K_CALL) || (kind == K_CALLCC) || (kind == K_RST);
    res_d.taken    = taken;
    res_d.next_pc  = (taken && !is_ret) ? target : fall;
    res_d.push     = taken && is_push;
    res_d.pop      = taken && is_ret;
    res_d.ret_addr = fall;
    res_d.b_we     = (kind == K_LOOP);
    res_d.b        = b_dec;
  end

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_q     <= '0;
    end else begin
      if (load) begin
        out_valid <= 1'b1;
        res_q     <= res_d;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_taken    = res_q.taken;
  assign out_next_pc  = res_q.next_pc;
  assign out_push     = res_q.push;
  assign out_pop      = res_q.pop;
  assign out_ret_addr = res_q.ret_addr;
  assign out_b_we     = res_q.b_we;
  assign out_b        = res_q.b;
endmodule

// File: rtl/bru_unit_checker.sv
module bru_unit_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_taken,
  input logic [ADDR_W-1:0] out_next_pc,
  input logic              out_push,
  input logic              out_pop,
  input logic [ADDR_W-1:0] out_ret_addr,
  input logic              out_b_we,
  input logic [7:0]        out_b
);
  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_stall_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_next_pc) &&
      $stable(out_taken) && $stable(out_push) && $stable(out_pop) &&
      $stable(out_ret_addr) && $stable(out_b));

  assert_loop_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_b_we && !out_taken |-> out_b == 8'd0);

  assert_push_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_push |-> out_taken && !out_pop);

  assert_pop_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_pop |-> out_taken && out_next_pc == out_ret_addr);

  assert_fallthrough_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_taken |-> out_next_pc == out_ret_addr && !out_push && !out_pop);

  assert_reset_R12: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind bru_unit bru_unit_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_taken(out_taken),
  .out_next_pc(out_next_pc), .out_push(out_push), .out_pop(out_pop),
  .out_ret_addr(out_ret_addr), .out_b_we(out_b_we), .out_b(out_b)
);

// File: tb/bru_unit_test.sv
`timescale 1ns/1ps
module bru_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [7:0]  in_opcode = '0, in_flags = '0, in_b = '0;
  logic [15:0] in_pc = '0, in_imm = '0, in_hl = '0;
  logic        out_valid, out_ready = 1'b0;
  logic        out_taken, out_push, out_pop, out_b_we;
  logic [15:0] out_next_pc, out_ret_addr;
  logic [7:0]  out_b;

  always #2 clk = ~clk;

  bru_unit uut (.*);

  typedef struct {
    logic [7:0]  op;
    logic        taken;
    logic [15:0] next_pc;
    logic        push;
    logic        pop;
    logic [15:0] ret_addr;
    logic        b_we;
    logic [7:0]  b;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0, cycles = 0;
  bit wd_hit = 0;
  localparam int WD_LIMIT = 100000;

  bit          prev_stall = 0;
  logic [15:0] prev_npc;
  logic        prev_taken;

  function automatic bit cond_true(logic [2:0] c, logic [7:0] f);
    case (c)
      3'd0: return !f[6];
      3'd1: return f[6];
      3'd2: return !f[0];
      3'd3: return f[0];
      3'd4: return !f[2];
      3'd5: return f[2];
      3'd6: return !f[7];
      default: return f[7];
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] op);
    if (op == 8'hC3) return "R3";
    if (op[7:6] == 2'b11 && op[2:0] == 3'b010) return "R2 R3";
    if (op == 8'h18) return "R4";
    if (op == 8'h20 || op == 8'h28 || op == 8'h30 || op == 8'h38) return "R2 R4";
    if (op == 8'h10) return "R5";
    if (op == 8'hE9) return "R6";
    if (op == 8'hCD) return "R7";
    if (op[7:6] == 2'b11 && op[2:0] == 3'b100) return "R2 R7";
    if (op == 8'hC9) return "R9";
    if (op[7:6] == 2'b11 && op[2:0] == 3'b000) return "R2 R9";
    if (op[7:6] == 2'b11 && op[2:0] == 3'b111) return "R8";
    return "R11";
  endfunction

  function automatic exp_t model(logic [7:0] op, logic [7:0] f, logic [15:0] pc,
                                 logic [15:0] imm, logic [15:0] hl, logic [7:0] b);
    exp_t e;
    int len = 1, d, tgt = 0;
    bit tk = 0, ps = 0, pp = 0, jumpto = 0;
    d = int'(imm[7:0]);
    if (d >= 128) d -= 256;
    e.op = op; e.b_we = 0; e.b = b - 8'd1;
    if (op == 8'hC3) begin len = 3; tk = 1; tgt = imm; end
    else if (op == 8'hCD) begin len = 3; tk = 1; ps = 1; tgt = imm; end
    else if (op == 8'hC9) begin tk = 1; pp = 1; end
    else if (op == 8'hE9) begin tk = 1; tgt = hl; end
    else if (op == 8'h18) begin len = 2; tk = 1; tgt = pc + 2 + d; end
    else if (op == 8'h10) begin
      len = 2; e.b_we = 1; tk = (e.b != 0); tgt = pc + 2 + d;
    end
    else if (op == 8'h20 || op == 8'h28 || op == 8'h30 || op == 8'h38) begin
      len = 2; tk = cond_true({1'b0, op[4:3]}, f); tgt = pc + 2 + d;
    end
    else if (op[7:6] == 2'b11) begin
      case (op[2:0])
        3'b010: begin len = 3; tk = cond_true(op[5:3], f); tgt = imm; end
        3'b100: begin len = 3; tk = cond_true(op[5:3], f); ps = tk; tgt = imm; end
        3'b000: begin tk = cond_true(op[5:3], f); pp = tk; end
        3'b111: begin tk = 1; ps = 1; tgt = op & 8'h38; end
        default: ;
      endcase
    end
    e.ret_addr = 16'((pc + len) & 16'hFFFF);
    e.taken = tk; e.push = ps; e.pop = pp;
    jumpto = tk && !pp;
    e.next_pc = jumpto ? 16'(tgt & 16'hFFFF) : e.ret_addr;
    return e;
  endfunction

  task automatic compare(exp_t e);
    bit bad;
    checks++;
    bad = (out_taken !== e.taken) || (out_next_pc !== e.next_pc) ||
          (out_push !== e.push) || (out_pop !== e.pop) ||
          (out_ret_addr !== e.ret_addr) || (out_b_we !== e.b_we) ||
          (e.b_we && out_b !== e.b);
    if (bad) begin
      errors++;
      $display("FAIL %s R10 op=%02h actual tk=%0b npc=%04h push=%0b pop=%0b ret=%04h bwe=%0b b=%02h expected tk=%0b npc=%04h push=%0b pop=%0b ret=%04h bwe=%0b b=%02h",
        tag_of(e.op), e.op, out_taken, out_next_pc, out_push, out_pop, out_ret_addr,
        out_b_we, out_b, e.taken, e.next_pc, e.push, e.pop, e.ret_addr, e.b_we, e.b);
    end
  endtask

  // Called 1 ns after a falling edge, once inputs for the coming edge are set.
  task automatic settle(output bit accepted);
    cycles++;
    if (cycles > WD_LIMIT) wd_hit = 1;
    checks++;
    if (in_ready !== (!out_valid || out_ready)) begin
      errors++;
      $display("FAIL R1 in_ready actual %0b expected %0b", in_ready, !out_valid || out_ready);
    end
    if (prev_stall) begin
      checks++;
      if (out_valid !== 1'b1 || out_next_pc !== prev_npc || out_taken !== prev_taken) begin
        errors++;
        $display("FAIL R1 hold actual v=%0b npc=%04h tk=%0b expected v=1 npc=%04h tk=%0b",
                 out_valid, out_next_pc, out_taken, prev_npc, prev_taken);
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_npc = out_next_pc;
    prev_taken = out_taken;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 unexpected result actual valid=1 expected valid=0");
      end else compare(exp_q.pop_front());
    end
    accepted = in_valid && in_ready;
    if (accepted) exp_q.push_back(model(in_opcode, in_flags, in_pc, in_imm, in_hl, in_b));
  endtask

  task automatic send(logic [7:0] op, logic [7:0] f, logic [15:0] pc,
                      logic [15:0] imm, logic [15:0] hl, logic [7:0] b);
    bit acc = 0;
    in_opcode = op; in_flags = f; in_pc = pc; in_imm = imm; in_hl = hl; in_b = b;
    in_valid = 1'b1;
    while (!acc && !wd_hit) begin
      out_ready = ($urandom_range(0, 9) < 7);
      #1 settle(acc);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic idle(int n, bit rdy_all);
    bit acc;
    for (int i = 0; i < n && !wd_hit; i++) begin
      out_ready = rdy_all ? 1'b1 : ($urandom_range(0, 9) < 7);
      #1 settle(acc);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R12 during reset actual v=%0b rdy=%0b expected v=0 rdy=1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R12 after reset actual v=%0b rdy=%0b expected v=0 rdy=1", out_valid, in_ready);
    end

    // Sweep of every opcode with all flags clear and all flags set (R2, R11).
    for (int o = 0; o < 256; o++) begin
      send(8'(o), 8'h00, 16'($urandom), 16'($urandom), 16'($urandom), 8'($urandom));
      send(8'(o), 8'hFF, 16'($urandom), 16'($urandom), 16'($urandom), 8'($urandom));
      if (o % 37 == 0) idle(2, 0);
    end

    // Each condition code against a single flag set (R2).
    for (int c = 0; c < 8; c++) begin
      send(8'hC2 | 8'(c << 3), 8'h01, 16'h1000, 16'hBEEF, 16'h0, 8'h0);
      send(8'hC2 | 8'(c << 3), 8'h04, 16'h1000, 16'hBEEF, 16'h0, 8'h0);
      send(8'hC2 | 8'(c << 3), 8'h40, 16'h1000, 16'hBEEF, 16'h0, 8'h0);
      send(8'hC2 | 8'(c << 3), 8'h80, 16'h1000, 16'hBEEF, 16'h0, 8'h0);
    end

    // Loop corners (R5): B=1 exits, B=0 wraps and branches, B=2 branches back.
    send(8'h10, 8'h00, 16'h2000, 16'h00FE, 16'h0, 8'h01);
    send(8'h10, 8'h00, 16'h2000, 16'h00FE, 16'h0, 8'h00);
    send(8'h10, 8'h00, 16'h2000, 16'h00FE, 16'h0, 8'h02);
    // Relative corners (R4): wrap below zero and above the top.
    send(8'h18, 8'h00, 16'h0000, 16'h0080, 16'h0, 8'h0);
    send(8'h18, 8'h00, 16'hFFFE, 16'h007F, 16'h0, 8'h0);
    send(8'h38, 8'h01, 16'h0010, 16'h00F0, 16'h0, 8'h0);
    send(8'h38, 8'h00, 16'h0010, 16'h00F0, 16'h0, 8'h0);
    // Restart vectors (R8), indirect (R6), call/return (R7, R9), end-of-space wrap (R10).
    send(8'hFF, 8'h00, 16'h4321, 16'h0, 16'h0, 8'h0);
    send(8'hC7, 8'h00, 16'hFFFF, 16'h0, 16'h0, 8'h0);
    send(8'hE9, 8'h00, 16'h1234, 16'h0, 16'hCAFE, 8'h0);
    send(8'hCD, 8'h00, 16'hFFFE, 16'h5678, 16'h0, 8'h0);
    send(8'hC9, 8'h00, 16'h3000, 16'h0, 16'h0, 8'h0);
    send(8'hC8, 8'h00, 16'h3000, 16'h0, 16'h0, 8'h0);
    send(8'hC8, 8'h40, 16'h3000, 16'h0, 16'h0, 8'h0);

    // Random mix under back-pressure.
    for (int k = 0; k < 400 && !wd_hit; k++) begin
      send(8'($urandom), 8'($urandom), 16'($urandom), 16'($urandom),
           16'($urandom), 8'($urandom_range(0, 3)));
      if (k % 11 == 0) idle(3, 0);
    end

    idle(4, 1);
    checks++;
    if (exp_q.size() != 0 || out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 drain actual pending=%0d expected 0", exp_q.size());
    end
    if (wd_hit) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual %0d cycles expected below %0d", cycles, WD_LIMIT);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule